// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between a CPU's external-data move requests and two memories. One is a small internal expanded RAM. The other is anything hung on a multiplexed external bus. For each request, the block builds an effective address and decides which side serves it. An internal access is a single-cycle chip-select to a synchronous RAM. An external access is a fixed sequence of bus phases: the address low byte is put on the shared low port and latched by ALE, then a read or write strobe is driven active low. The high address byte appears on a separate high port.

Six configuration bits shape the behaviour. They cover the size of the internal window, forcing every access outside, a long strobe for slow peripherals, and a page mode that leaves the high port showing its general-purpose latch value. A final bit makes ALE pulse only during external accesses instead of running continuously. The CPU issues a one-cycle request and waits for a one-cycle acknowledge. On reads, the data arrives with that acknowledge.

Top module: `xmem_ctrl`

## Requirements
- R1: With the external-select bit at 0 and the effective address below the window limit, an access is internal. In the cycle after the request, `ram_cs` is high for one cycle, with `ram_addr` equal to the low address bits and `ram_we` set for writes. In that cycle ALE is not forced and no strobe goes low. `ack` follows one cycle later, and on a read `rdata` then equals `ram_rdata`.
- R2: Configuration bits 3:2 set the window limit: 00 gives 256 bytes, 01 gives 512, 10 gives 1024 and 11 gives 2048. Any effective address at or above the limit uses the external bus.
- R3: When configuration bit 1 (external-select) is 1, every access uses the external bus, whatever its address.
- R4: An unstretched external access lasts 6 cycles after the request edge. Phase 0 has ALE high. Phase 1 holds the address. Phases 2 to 4 have the strobe low, with `rd_n` for reads and `wr_n` for writes. Phase 5 is the release. The two strobes are never low together, and neither is low while ALE is high.
- R5: When configuration bit 4 (stretch) is 1 at the request, the strobe stays low for 15 cycles. The whole external access then lasts 18 cycles.
- R6: During phases 0 and 1, `ad_out` carries effective-address bits 7:0 with `ad_oe` high. On writes, it then carries the write data up to and including the release phase. On reads, `ad_oe` is low from phase 2 on. Read data is sampled from `ad_in` on the edge that ends the strobe.
- R7: The effective high byte is the request address bits 15:8 only for a wide (16-bit pointer) access with configuration bit 5 (page) at 0. Otherwise, meaning for a narrow 8-bit access or in page mode, it is `port_hi_latch`. `a_hi` shows the effective high byte during external accesses and `port_hi_latch` at all other times.
- R8: With configuration bit 0 at 0, ALE outside external accesses is high in every cycle whose count since reset release is a multiple of 3. With bit 0 at 1, ALE is high only in phase 0 of an external access.
- R9: Reset leaves the configuration at 0x0C (2048-byte window, constant-rate ALE, no stretch, no page, no external-select) and all outputs idle. A write with `cfg_we` loads `cfg_wdata` on that edge.
- R10: `ack` is high for exactly one cycle per access, in the cycle the strobe returns high. Requests that arrive while an access is in progress, including its acknowledge cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 6 | Configuration value |
| req | input | 1 | One-cycle access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit register-indirect |
| req_addr | input | AW (16) | Requested address |
| req_wdata | input | DW (8) | Write data |
| port_hi_latch | input | AW-DW (8) | Latched general-purpose value of the high port |
| ack | output | 1 | One-cycle completion |
| rdata | output | DW (8) | Read data, valid with ack |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | DW (8) | Low port output value |
| ad_oe | output | 1 | Low port drive enable |
| ad_in | input | DW (8) | Low port input value |
| a_hi | output | AW-DW (8) | High port value |
| ram_cs | output | 1 | Internal RAM select |
| ram_we | output | 1 | Internal RAM write enable |
| ram_addr | output | RAM_AW (11) | Internal RAM address |
| ram_wdata | output | DW (8) | Internal RAM write data |
| ram_rdata | input | DW (8) | Internal RAM read data, one cycle after select |

## Verification
The free-running ALE cadence and the ALE of an external access compete for the same pin. An access can begin on any phase of the divide-by-three counter. The bench starts external accesses after gaps of zero, one and two idle cycles, so that each access lands on a different counter phase. The reference model expects only the access's own phase-0 pulse for the whole external access. After the access, it expects the cadence to resume on the phase set by reset release. Requests placed in the select and acknowledge cycles of an internal access test the other overlap. They must leave memory and bus untouched, which a later read-back confirms.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_INT     = 2'd1,
        ST_INT_END = 2'd2,
        ST_EXT     = 2'd3
    } xm_state_e;

    // configuration bit positions
    localparam int CFG_W        = 6;
    localparam int CFG_ALE_ACC  = 0;
    localparam int CFG_EXT      = 1;
    localparam int CFG_SIZE_LO  = 2;
    localparam int CFG_STRETCH  = 4;
    localparam int CFG_PAGE     = 5;
    localparam logic [CFG_W-1:0] CFG_RESET = 6'h0C;

    // smallest internal window is 2**BASE_LOG bytes
    localparam int BASE_LOG = 8;

endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          ext_sel,
    input  logic [1:0]    size,
    input  logic          page,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic [AW-DW-1:0] port_hi,
    output logic [AW-1:0] ea,
    output logic          go_int
);
    logic [AW-1:0] above;

    always_comb begin
        ea     = {((wide && !page) ? addr[AW-1:DW] : port_hi), addr[DW-1:0]};
        above  = ea >> (BASE_LOG + int'(size));
        go_int = !ext_sel && (above == '0);
    end

endmodule

// File: rtl/xmem_ale_div.sv
module xmem_ale_div #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int RAM_AW    = 11,
    parameter int SHORT_STB = 3,
    parameter int LONG_STB  = 15,
    parameter int ALE_DIV   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [AW-DW-1:0]  port_hi_latch,
    output logic              ack,
    output logic [DW-1:0]     rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DW-1:0]     ad_out,
    output logic              ad_oe,
    input  logic [DW-1:0]     ad_in,
    output logic [AW-DW-1:0]  a_hi,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata
);
    localparam int HW = AW - DW;
    localparam int CW = $clog2(LONG_STB + 3);

    typedef struct packed {
        xm_state_e        st;
        logic [CW-1:0]    cnt;
        logic [CFG_W-1:0] cfg;
        logic             we;
        logic             stretch;
        logic [AW-1:0]    ea;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rd;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] dec_ea;
    logic          dec_int;
    logic          ale_tick;
    logic          ale_acc_only;
    logic [CW-1:0] stb_len;
    logic          in_ext;
    logic          stb_on;
    logic          addr_phase;

    xmem_decode #(.AW(AW), .DW(DW)) i_dec (
        .ext_sel (r_q.cfg[CFG_EXT]),
        .size    (r_q.cfg[CFG_SIZE_LO +: 2]),
        .page    (r_q.cfg[CFG_PAGE]),
        .wide    (req_wide),
        .addr    (req_addr),
        .port_hi (port_hi_latch),
        .ea      (dec_ea),
        .go_int  (dec_int)
    );

    xmem_ale_div #(.DIV(ALE_DIV)) i_ale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ale_tick)
    );

    // phase decode of the registered state
    always_comb begin
        stb_len    = r_q.stretch ? CW'(LONG_STB) : CW'(SHORT_STB);
        in_ext     = (r_q.st == ST_EXT);
        stb_on     = in_ext && (r_q.cnt >= CW'(2)) && (r_q.cnt <= stb_len + CW'(1));
        addr_phase = in_ext && (r_q.cnt <= CW'(1));
    end

    // next-state computation
    always_comb begin
        r_d = r_q;
        if (cfg_we) r_d.cfg = cfg_wdata;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.we      = req_we;
                    r_d.ea      = dec_ea;
                    r_d.wdata   = req_wdata;
                    r_d.stretch = r_q.cfg[CFG_STRETCH];
                    r_d.cnt     = '0;
                    r_d.st      = dec_int ? ST_INT : ST_EXT;
                end
            end
            ST_INT:     r_d.st = ST_INT_END;
            ST_INT_END: r_d.st = ST_IDLE;
            ST_EXT: begin
                if (!r_q.we && (r_q.cnt == stb_len + CW'(1))) r_d.rd = ad_in;
                if (r_q.cnt == stb_len + CW'(2)) r_d.st = ST_IDLE;
                else                             r_d.cnt = r_q.cnt + CW'(1);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cfg <= CFG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign ale_acc_only = r_q.cfg[CFG_ALE_ACC];
    assign ale       = in_ext ? (r_q.cnt == '0) : (!ale_acc_only && ale_tick);
    assign rd_n      = !(stb_on && !r_q.we);
    assign wr_n      = !(stb_on && r_q.we);
    assign ad_oe     = addr_phase || (in_ext && r_q.we);
    assign ad_out    = addr_phase ? r_q.ea[DW-1:0] : r_q.wdata;
    assign a_hi      = in_ext ? r_q.ea[AW-1 -: HW] : port_hi_latch;
    assign ack       = (in_ext && (r_q.cnt == stb_len + CW'(2))) || (r_q.st == ST_INT_END);
    assign rdata     = (r_q.st == ST_INT_END) ? ram_rdata : r_q.rd;
    assign ram_cs    = (r_q.st == ST_INT);
    assign ram_we    = r_q.we;
    assign ram_addr  = r_q.ea[RAM_AW-1:0];
    assign ram_wdata = r_q.wdata;

endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic ack,
    input logic ram_cs,
    input logic ale_acc_only
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R4

    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R4

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10

    AST_ACK_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> ack); // R10

    AST_RAM_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (rd_n && wr_n && !ad_oe)); // R1

    AST_ALE_ACCESS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && ale_acc_only) |-> ad_oe); // R8

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R6

endmodule

bind xmem_ctrl xmem_ctrl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ale          (ale),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .ad_oe        (ad_oe),
    .ack          (ack),
    .ram_cs       (ram_cs),
    .ale_acc_only (ale_acc_only)
);

// File: tb/test_xmem_ctrl.sv
module test_xmem_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  p2_drv = '0;
    logic        ack, ale, rd_n, wr_n, ad_oe, ram_cs, ram_we;
    logic [7:0]  rdata, ad_out, a_hi, ram_wdata, ad_in, ram_q;
    logic [10:0] ram_addr;
    logic [7:0]  ext_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_ctrl i_xmem_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .port_hi_latch(p2_drv), .ack(ack), .rdata(rdata),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .a_hi(a_hi), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_q)
    );

    // external device: returns its pattern only while the read strobe is low
    assign ad_in = rd_n ? 8'h00 : ext_val;

    // internal RAM with one-cycle read latency
    logic [7:0] mem    [0:2047];
    logic [7:0] shadow [0:2047];
    always @(posedge clk) begin
        if (ram_cs) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_q <= mem[ram_addr];
        end
    end

    // reference model state
    typedef struct {
        int       ale_k;   // 0 cadence, 1 forced high, 2 forced low
        bit       rdn, wrn, oe;
        bit [7:0] p0;
        int       p2;      // -1 = live port latch
        bit       ack, cs, csw;
        bit [10:0] caddr;
        bit       rchk;
        bit [7:0] rval;
        int       tag;
    } exp_t;

    exp_t     q[$];
    bit [5:0] m_cfg = 6'h0C;   // R9 reset value
    int       e_cnt;
    bit       in_reset = 1'b1;
    int       vectors = 0;
    int       fails = 0;
    int       wd = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_cnt <= 0;
        else        e_cnt <= e_cnt + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            fails++;
            $display("FAIL R10 watchdog: cycles=%0d expected<=%0d", wd, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic exp_t idle_exp();
        exp_t x;
        x.ale_k = 0; x.rdn = 1; x.wrn = 1; x.oe = 0; x.p0 = 0; x.p2 = -1;
        x.ack = 0; x.cs = 0; x.csw = 0; x.caddr = 0; x.rchk = 0; x.rval = 0;
        x.tag = 8;
        return x;
    endfunction

    task automatic check_now(output bit had);
        exp_t c;
        int tg;
        bit bad;
        logic exp_ale;
        logic [7:0] ep2;
        had = (q.size() > 0);
        if (had) c = q.pop_front(); else c = idle_exp();
        tg = had ? c.tag : (in_reset ? 9 : 8);  // idle: R8 cadence, R9 reset
        exp_ale = (c.ale_k == 0) ? (!m_cfg[0] && (e_cnt % 3 == 0)) : (c.ale_k == 1);
        ep2 = (c.p2 < 0) ? p2_drv : 8'(c.p2);
        bad = (ale !== exp_ale) || (rd_n !== c.rdn) || (wr_n !== c.wrn) ||
              (ad_oe !== c.oe) || (ack !== c.ack) || (ram_cs !== c.cs) || (a_hi !== ep2);
        if (c.oe && ad_out !== c.p0) bad = 1;
        if (c.cs && ((ram_we !== c.csw) || (ram_addr !== c.caddr) ||
                     (c.csw && ram_wdata !== c.p0))) bad = 1;
        if (c.rchk && rdata !== c.rval) bad = 1;
        vectors++;
        if (bad) begin
            fails++;
            $display("FAIL R%0d cycle %0d: got ale=%b rd_n=%b wr_n=%b oe=%b ad=%h hi=%h ack=%b cs=%b ra=%h rdata=%h | exp ale=%b rd_n=%b wr_n=%b oe=%b ad=%h hi=%h ack=%b cs=%b ra=%h rdata=%h",
                     tg, e_cnt, ale, rd_n, wr_n, ad_oe, ad_out, a_hi, ack, ram_cs, ram_addr, rdata,
                     exp_ale, c.rdn, c.wrn, c.oe, c.p0, ep2, c.ack, c.cs, c.caddr, c.rval);
        end
    endtask

    // expected cycle sequence of one accepted access (R1..R7, R10)
    task automatic plan(input bit w, input bit wd_acc, input logic [15:0] a,
                        input logic [7:0] d, input int tag);
        logic [7:0]  hi;
        logic [15:0] ea;
        int lim, s;
        bit inter;
        exp_t x;
        hi    = (wd_acc && !m_cfg[5]) ? a[15:8] : p2_drv;      // R7
        ea    = {hi, a[7:0]};
        lim   = 256 << m_cfg[3:2];                             // R2
        inter = !m_cfg[1] && (int'(ea) < lim);                 // R1, R3
        if (inter) begin
            x = idle_exp(); x.tag = tag;
            x.cs = 1; x.csw = w; x.caddr = ea[10:0]; x.p0 = d;
            q.push_back(x);
            x = idle_exp(); x.tag = tag; x.ack = 1;
            x.rchk = !w; x.rval = shadow[ea[10:0]];
            q.push_back(x);
            if (w) shadow[ea[10:0]] = d;
        end else begin
            s = m_cfg[4] ? 15 : 3;                             // R4, R5
            ext_val = a[7:0] ^ 8'hA5;
            for (int p = 0; p <= s + 2; p++) begin
                bit stb;
                x = idle_exp(); x.tag = tag;
                stb = (p >= 2) && (p <= s + 1);
                x.ale_k = (p == 0) ? 1 : 2;
                x.rdn = !(stb && !w);
                x.wrn = !(stb && w);
                x.oe  = (p <= 1) || w;                         // R6
                x.p0  = (p <= 1) ? ea[7:0] : d;
                x.p2  = int'(hi);
                x.ack = (p == s + 2);                          // R10
                x.rchk = (p == s + 2) && !w;
                x.rval = a[7:0] ^ 8'hA5;
                q.push_back(x);
            end
        end
    endtask

    task automatic do_cycle(input bit r, input bit w, input bit wd_acc,
                            input logic [15:0] a, input logic [7:0] d, input int tag,
                            input bit cw, input logic [5:0] cv);
        bit had;
        @(negedge clk);
        check_now(had);
        req = r; req_we = w; req_wide = wd_acc; req_addr = a; req_wdata = d;
        cfg_we = cw; cfg_wdata = cv;
        if (r && !had) plan(w, wd_acc, a, d, tag);   // busy requests dropped (R10)
        if (cw) m_cfg = cv;
    endtask

    task automatic idle(input int n);
        repeat (n) do_cycle(0, 0, 0, 16'h0, 8'h0, 8, 0, 6'h0);
    endtask

    task automatic acc(input bit w, input bit wd_acc, input logic [15:0] a,
                       input logic [7:0] d, input int tag);
        do_cycle(1, w, wd_acc, a, d, tag, 0, 6'h0);
        while (q.size() > 0) do_cycle(0, 0, 0, 16'h0, 8'h0, 8, 0, 6'h0);
    endtask

    task automatic setcfg(input logic [5:0] v);
        do_cycle(0, 0, 0, 16'h0, 8'h0, 9, 1, v);   // R9 layout write
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]    = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        // R9: outputs idle while held in reset
        repeat (2) begin
            bit had;
            @(negedge clk);
            check_now(had);
        end
        rst_n = 1'b1;
        in_reset = 1'b0;
        idle(7);                                   // R8 constant cadence
        // R1 internal write / read-back, top of 2 KB window
        acc(1, 1, 16'h0123, 8'h3C, 1);
        acc(0, 1, 16'h0123, 8'h00, 1);
        acc(0, 1, 16'h07FF, 8'h00, 1);
        // R2 first address past the window, R4 write timing
        acc(0, 1, 16'h0800, 8'h00, 2);
        acc(1, 1, 16'h0800, 8'h5E, 4);
        // R2 each window size
        setcfg(6'h00);
        acc(0, 1, 16'h00FF, 8'h00, 2);
        acc(0, 1, 16'h0100, 8'h00, 2);
        setcfg(6'h04);
        acc(0, 1, 16'h01FF, 8'h00, 2);
        acc(0, 1, 16'h0200, 8'h00, 2);
        setcfg(6'h08);
        acc(0, 1, 16'h03FF, 8'h00, 2);
        acc(0, 1, 16'h0400, 8'h00, 2);
        // R3 external-select forces the bus
        setcfg(6'h0E);
        acc(0, 1, 16'h0010, 8'h00, 3);
        acc(1, 1, 16'h0005, 8'hC3, 3);
        // R5 stretched strobes
        setcfg(6'h1C);
        acc(1, 1, 16'h9ABC, 8'h81, 5);
        acc(0, 1, 16'h9ABC, 8'h00, 5);
        // R7 page mode and narrow accesses
        setcfg(6'h2C);
        p2_drv = 8'h12;
        acc(0, 1, 16'h4321, 8'h00, 7);
        setcfg(6'h0C);
        p2_drv = 8'h00;
        acc(0, 0, 16'hFF40, 8'h00, 7);
        p2_drv = 8'h34;
        acc(1, 0, 16'h0055, 8'h6A, 7);
        p2_drv = 8'h00;
        // R8 ALE only on access
        setcfg(6'h0D);
        idle(5);
        acc(0, 1, 16'h1000, 8'h00, 8);
        idle(4);
        setcfg(6'h0C);
        // R10 requests during select and acknowledge cycles are ignored
        do_cycle(1, 0, 1, 16'h0010, 8'h00, 10, 0, 6'h0);
        do_cycle(1, 1, 1, 16'h0011, 8'h99, 10, 0, 6'h0);
        do_cycle(1, 1, 1, 16'h0012, 8'h98, 10, 0, 6'h0);
        idle(3);
        acc(0, 1, 16'h0011, 8'h00, 10);
        acc(0, 1, 16'h0012, 8'h00, 10);
        // R10 request in the middle of an external access
        do_cycle(1, 0, 1, 16'h2000, 8'h00, 10, 0, 6'h0);
        do_cycle(0, 0, 0, 16'h0, 8'h0, 10, 0, 6'h0);
        do_cycle(1, 1, 1, 16'h0003, 8'h77, 10, 0, 6'h0);
        while (q.size() > 0) do_cycle(0, 0, 0, 16'h0, 8'h0, 8, 0, 6'h0);
        acc(0, 1, 16'h0003, 8'h00, 10);
        // R8 access ALE against every cadence phase
        for (int g = 0; g < 3; g++) begin
            idle(g);
            acc(0, 1, 16'h3000 + 16'(g), 8'h00, 4);
        end
        idle(6);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule